// File: doc/BRIEF.md
# Five-Pin GPIO Port with Peripheral Override

This block is a small bidirectional general-purpose I/O port that sits on a simple register bus. Software controls each pin through three registers. A direction register sets whether the pin drives or listens. An output latch holds the value a driving pin puts out. A pin-level register returns what is present on the pads, after a two-flop synchronizer. A fourth address holds one global switch that enables the weak pull-ups.

On-chip peripherals can take a pin over without software's help. They can force it to drive their own data, or force it to be an input. These overrides act only on the registered pad controls (`pad_oe`, `pad_do`, `pad_pu`). They are never stored in the direction register. Software can therefore read the direction register, change it and write it back, and no peripheral state is lost or copied into it. A pin's pull-up is on only while the global enable is set and the pin is not actually driving. The synchronized pin levels also go out on `pin_sync`, so a peripheral input such as a timer clock can use a pin whatever its direction bit says.

Top module: `gpio_ovr_port`

## Requirements
- R1: After a synchronous reset the direction register reads 0x1F (all pins inputs), the latch reads 0x00, the config register reads 0x00 (pull-ups globally off), and `pad_oe`, `pad_do` and `pad_pu` are all 0.
- R2: With no override, a pin whose direction bit is 0 has `pad_oe`=1 and a pin whose bit is 1 has `pad_oe`=0. `pad_do` carries the latch bit. Both outputs are registered and follow a register write one clock after the write edge.
- R3: Reads are combinational. Address 1 returns the latch, address 2 returns the direction register, and address 3 returns the global pull-up enable in bit 4 with bits 3..0 reading as 0. Address 0 returns pin levels, never the latch.
- R4: A write to address 0 loads the output latch exactly as a write to address 1 does, so writing 0 to either address clears the latch.
- R5: Address 0 reads the pad levels through two flops. A change on `pad_in` appears on `pin_sync` and on the address-0 read two clock edges later, and not after one.
- R6: `pad_pu` for a pin is 1 only when the global enable (address 3, bit 4) is 1 and the pin's registered `pad_oe` is 0. Clearing the enable turns every pull-up off one clock later.
- R7: When `per_oe_force[i]`=1, `pad_oe[i]`=1 and `pad_do[i]`=`per_do[i]` on the next clock, whatever the direction and latch bits are. This override wins over `per_ie_force[i]`.
- R8: When only `per_ie_force[i]`=1, `pad_oe[i]`=0 on the next clock even if the direction bit is 0. The pin's pull-up then follows the global enable.
- R9: Overrides never change the direction register. It reads back the last value software wrote while any override is active.
- R10: `pin_sync` shows the synchronized level of every pin, including pins that are currently driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | 0 pin level / latch write, 1 latch, 2 direction, 3 config |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 5 | Combinational read data |
| pad_in | input | 5 | Raw pad input levels |
| pin_sync | output | 5 | Synchronized pad levels for peripheral inputs |
| pad_oe | output | 5 | Registered per-pin output enable |
| pad_do | output | 5 | Registered per-pin output data |
| pad_pu | output | 5 | Registered per-pin weak pull-up enable |
| per_oe_force | input | 5 | Peripheral forces pin to drive |
| per_do | input | 5 | Peripheral drive data |
| per_ie_force | input | 5 | Peripheral forces pin to be an input |

## Verification
The bench first sets pins 0 and 1 as outputs and then applies both override types on top. A design that wrote the override back into the direction register would read 0x1C back wrongly after that. It holds pin 4 under both forces at once and pin 0 under an input force with a direction bit of 0. A reversed priority or an input force that is ignored would show up as a wrong `pad_oe`. It checks `pin_sync` one and two edges after a pad change, which catches a synchronizer with one flop too few or too many. It also checks that the pull-ups drop on output pins and when the global enable is cleared. Finally it checks that a write to address 0 lands in the latch while reads of address 0 still return the pins.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_PINS = 2'd0,
    A_LAT  = 2'd1,
    A_DIR  = 2'd2,
    A_CFG  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pin_sync
);
  logic [NPINS-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      pin_sync <= '0;
    end else begin
      meta_q   <= pad_in;
      pin_sync <= meta_q;
    end
  end

  // cycles since reset, saturating, so the latency check never looks into reset
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  a_r5_two_flop_latency: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (pin_sync == $past(pad_in, 2)));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_ovr_pkg::*;
#(
  parameter int NPINS  = 5,
  parameter int DATA_W = 5,
  parameter int PU_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPINS-1:0]  pin_sync,
  output logic [DATA_W-1:0] rdata,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  lat_q,
  output logic              pu_en_q
);
  reg_addr_e sel;
  assign sel = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '1;
      lat_q   <= '0;
      pu_en_q <= 1'b0;
    end else if (we) begin
      case (sel)
        A_PINS, A_LAT: lat_q   <= wdata[NPINS-1:0];
        A_DIR:         dir_q   <= wdata[NPINS-1:0];
        A_CFG:         pu_en_q <= wdata[PU_BIT];
        default:       ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      A_PINS:  rdata[NPINS-1:0] = pin_sync;
      A_LAT:   rdata[NPINS-1:0] = lat_q;
      A_DIR:   rdata[NPINS-1:0] = dir_q;
      A_CFG:   rdata[PU_BIT]    = pu_en_q;
      default: rdata = '0;
    endcase
  end

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (dir_q == '1 && lat_q == '0 && !pu_en_q));

  a_r9_dir_software_only: assert property (@(posedge clk) disable iff (rst)
    !(we && sel == A_DIR) |=> $stable(dir_q));

  a_r4_pin_addr_loads_latch: assert property (@(posedge clk) disable iff (rst)
    (we && sel == A_PINS) |=> (lat_q == $past(wdata[NPINS-1:0])));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NPINS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] lat_q,
  input  logic             pu_en,
  input  logic [NPINS-1:0] ovr_oe,
  input  logic [NPINS-1:0] ovr_do,
  input  logic [NPINS-1:0] ovr_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_do,
  output logic [NPINS-1:0] pad_pu
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic oe_c, do_c;

    // drive force beats input force, input force beats the direction bit
    always_comb begin
      if (ovr_oe[i]) begin
        oe_c = 1'b1;
        do_c = ovr_do[i];
      end else begin
        oe_c = ovr_in[i] ? 1'b0 : ~dir_q[i];
        do_c = lat_q[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i] <= 1'b0;
        pad_do[i] <= 1'b0;
        pad_pu[i] <= 1'b0;
      end else begin
        pad_oe[i] <= oe_c;
        pad_do[i] <= do_c;
        pad_pu[i] <= pu_en & ~oe_c;
      end
    end

    a_r7_force_drive: assert property (@(posedge clk) disable iff (rst)
      ovr_oe[i] |=> (pad_oe[i] && pad_do[i] == $past(ovr_do[i])));

    a_r8_force_input: assert property (@(posedge clk) disable iff (rst)
      (ovr_in[i] && !ovr_oe[i]) |=> !pad_oe[i]);

    a_r6_no_pullup_on_driver: assert property (@(posedge clk) disable iff (rst)
      pad_pu[i] |-> !pad_oe[i]);
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int NPINS  = 5,
  parameter int DATA_W = 5,
  parameter int PU_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pin_sync,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_do,
  output logic [NPINS-1:0]  pad_pu,
  input  logic [NPINS-1:0]  per_oe_force,
  input  logic [NPINS-1:0]  per_do,
  input  logic [NPINS-1:0]  per_ie_force
);
  logic [NPINS-1:0] dir_q, lat_q;
  logic             pu_en_q;

  gpio_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pin_sync(pin_sync)
  );

  gpio_regfile #(.NPINS(NPINS), .DATA_W(DATA_W), .PU_BIT(PU_BIT)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pin_sync(pin_sync), .rdata(bus_rdata),
    .dir_q(dir_q), .lat_q(lat_q), .pu_en_q(pu_en_q)
  );

  gpio_pin_mux #(.NPINS(NPINS)) u_mux (
    .clk(clk), .rst(rst), .dir_q(dir_q), .lat_q(lat_q), .pu_en(pu_en_q),
    .ovr_oe(per_oe_force), .ovr_do(per_do), .ovr_in(per_ie_force),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
  );

  a_r6_global_pullup_off: assert property (@(posedge clk) disable iff (rst)
    !pu_en_q |=> (pad_pu == '0));
endmodule

// File: tb/gpio_ovr_port_bench.sv
module gpio_ovr_port_bench;
  localparam int NP = 5;
  localparam int SEL_RD = 0, SEL_OE = 1, SEL_DO = 2, SEL_PU = 3, SEL_SY = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0, pad_in = '0;
  logic [NP-1:0] per_oe_force = '0, per_do = '0, per_ie_force = '0;
  logic [NP-1:0] bus_rdata, pin_sync, pad_oe, pad_do, pad_pu;

  gpio_ovr_port u_gpio_ovr_port (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pin_sync(pin_sync), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu),
    .per_oe_force(per_oe_force), .per_do(per_do), .per_ie_force(per_ie_force)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    int         sel;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];
  int applied = 0, miscompares = 0;
  bit done = 0;

  function automatic logic [7:0] pick(int sel);
    case (sel)
      SEL_RD:  return {3'b0, bus_rdata};
      SEL_OE:  return {3'b0, pad_oe};
      SEL_DO:  return {3'b0, pad_do};
      SEL_PU:  return {3'b0, pad_pu};
      default: return {3'b0, pin_sync};
    endcase
  endfunction

  // monitor: compares queued expectations once their cycle arrives
  initial forever begin
    @(negedge clk);
    #2;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = pick(it.sel);
      applied++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic push(int sel, logic [7:0] exp, string req, int dly);
    item_t it;
    it.at = cyc + dly; it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(logic [1:0] a, logic [NP-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
    bus_addr = a;
    push(SEL_RD, exp, req, 0);
    @(negedge clk);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    settle(3);
    rst = 1'b0;
    // R1 reset state
    rd(2'd2, 8'h1F, "R1");
    rd(2'd1, 8'h00, "R1");
    rd(2'd3, 8'h00, "R1");
    push(SEL_OE, 8'h00, "R1", 0);
    push(SEL_PU, 8'h00, "R1", 0);
    push(SEL_DO, 8'h00, "R1", 0);
    settle(1);
    // R2 direction and latch to pads
    wr(2'd1, 5'h15);
    wr(2'd2, 5'h1C);
    push(SEL_OE, 8'h03, "R2", 1);
    push(SEL_DO, 8'h15, "R2", 1);
    settle(1);
    rd(2'd1, 8'h15, "R3");
    rd(2'd2, 8'h1C, "R3");
    // R4 port address writes latch
    wr(2'd0, 5'h0A);
    rd(2'd1, 8'h0A, "R4");
    push(SEL_DO, 8'h0A, "R4", 0);
    // R6 pull-ups globally off, then on for inputs only
    push(SEL_PU, 8'h00, "R6", 0);
    settle(1);
    wr(2'd3, 5'h1F);
    rd(2'd3, 8'h10, "R3");
    push(SEL_PU, 8'h1C, "R6", 0);
    settle(1);
    // R5 / R10 synchronizer latency, pins 0,1 driving
    pad_in = 5'h13;
    push(SEL_SY, 8'h00, "R5", 1);
    push(SEL_SY, 8'h13, "R10", 2);
    settle(2);
    rd(2'd0, 8'h13, "R5");
    // R7 drive force on pin 4
    per_oe_force = 5'h10; per_do = 5'h10;
    push(SEL_OE, 8'h13, "R7", 1);
    push(SEL_DO, 8'h1A, "R7", 1);
    push(SEL_PU, 8'h0C, "R6", 1);
    settle(1);
    // R8 input force on pin 0; pin 4 has both forces, drive wins (R7)
    per_ie_force = 5'h11;
    push(SEL_OE, 8'h12, "R8", 1);
    push(SEL_PU, 8'h0D, "R8", 1);
    settle(1);
    rd(2'd2, 8'h1C, "R9");
    wr(2'd2, 5'h00);
    push(SEL_OE, 8'h1E, "R8", 1);
    settle(1);
    rd(2'd2, 8'h00, "R9");
    // release overrides: direction register alone decides
    per_oe_force = '0; per_ie_force = '0;
    push(SEL_OE, 8'h1F, "R2", 1);
    push(SEL_PU, 8'h00, "R6", 1);
    settle(1);
    wr(2'd3, 5'h00);
    rd(2'd3, 8'h00, "R6");
    wr(2'd0, 5'h00);
    rd(2'd1, 8'h00, "R4");
    rd(2'd0, 8'h13, "R3");
    settle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule